// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block chooses where each of the two source operands of the instruction in the execute stage comes from in a five-stage in-order integer pipeline. Each operand has a source register index held in the decode/execute pipeline register. The block compares that index with the destination index and write enable of the instruction one stage ahead, in the execute/memory register, and of the instruction two stages ahead, in the memory/writeback register. It then drives a two-bit multiplexer select and the resulting operand value. When both older instructions target the register, the younger one, which is still in the execute/memory register, supplies the value. Register zero never takes part in a dependency.

The block also holds the eight-entry register file. Its single write port is fed from the memory/writeback stage, and its two read ports serve the decode stage. When a read asks for the register being written back in the same cycle, the read port returns the value being written, so an instruction three positions behind a producer sees the result without a bypass. The memory/writeback bypass value and the write data are the same final writeback value: the load data for a load, otherwise the ALU result. Stall generation, the ALU and the memories lie outside the block. An instruction that does not write a register is expected to present write enable low and destination zero.

This unit is purely combinational apart from the register array, so it has no state machine. Reset clears every register to zero.

Top module: `exec_bypass_unit`

## Requirements
- R1: When the execute/memory write enable is 1, its destination index is nonzero and equals an operand's source index, that operand's select is 2'b01 and its value is the execute/memory ALU result.
- R2: When the memory/writeback write enable is 1, its destination index is nonzero and equals an operand's source index, and R1 does not apply to that operand, the select is 2'b10 and the value is the final writeback value.
- R3: When both older stages match an operand under R1 and R2, the execute/memory stage wins: select 2'b01, value from the execute/memory ALU result.
- R4: A source index of zero never forwards (select 2'b00), and a decode read of register zero returns 0 even right after a write to register zero.
- R5: A stage whose write enable is 0 never forwards, even when its destination index matches.
- R6: The final writeback value is the load data when the load flag is 1 and the memory/writeback ALU result when it is 0.
- R7: After reset every register reads 0. A write with enable 1 to a nonzero index stores the final writeback value at the clock edge, and later reads return it.
- R8: A decode read whose index equals the nonzero index being written in the same cycle returns the value being written.
- R9: The two operands are resolved independently, so one operand can take the execute/memory value while the other takes the memory/writeback value in the same cycle.
- R10: With no match, the select is 2'b00 and the operand value is the register-file value carried in the decode/execute register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the register file |
| dec_rd_a_idx | input | 3 | Decode-stage read index, operand A |
| dec_rd_b_idx | input | 3 | Decode-stage read index, operand B |
| dec_rd_a_data | output | 32 | Decode-stage read data A, with write-through |
| dec_rd_b_data | output | 32 | Decode-stage read data B, with write-through |
| ex_src_a_idx | input | 3 | Source index of operand A in decode/execute register |
| ex_src_b_idx | input | 3 | Source index of operand B in decode/execute register |
| ex_rf_a_val | input | 32 | Register-file value of operand A carried from decode |
| ex_rf_b_val | input | 32 | Register-file value of operand B carried from decode |
| xm_wr_en | input | 1 | Execute/memory register write enable |
| xm_dst_idx | input | 3 | Execute/memory destination index |
| xm_alu_val | input | 32 | Execute/memory ALU result |
| mw_wr_en | input | 1 | Memory/writeback register write enable |
| mw_dst_idx | input | 3 | Memory/writeback destination index |
| mw_alu_val | input | 32 | Memory/writeback ALU result |
| mw_load_val | input | 32 | Memory/writeback load data |
| mw_is_load | input | 1 | 1 selects load data as the final writeback value |
| opnd_a_sel | output | 2 | Operand A source: 00 register file, 01 execute/memory, 10 memory/writeback |
| opnd_b_sel | output | 2 | Operand B source, same encoding |
| opnd_a_val | output | 32 | Bypassed operand A |
| opnd_b_val | output | 32 | Bypassed operand B |

## Verification
The bench replays a short program whose dependences sit at distances one, two and three. It checks every operand against the value that in-order execution would produce. A unit without the priority rule would hand back the older of two writes to the same register. A unit without write-through would leave the distance-three consumer with a stale register value. Cases where a disabled write or register zero still matches the source index catch a design that forwards on the index compare alone. A load at distance two catches a design that bypasses the ALU result where the load data belongs.

// File: rtl/byp_pkg.sv
package byp_pkg;

    // Operand source select encoding (decoded by the operand multiplexer)
    typedef enum logic [1:0] {
        SRC_RF = 2'b00,
        SRC_XM = 2'b01,
        SRC_MW = 2'b10
    } opnd_src_e;

endpackage

// File: rtl/byp_regfile.sv
module byp_regfile #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx  [NUM_RD],
    output logic [DATA_W-1:0] rd_data [NUM_RD]
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    // Entry zero is cleared by reset and never written.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 1; i < NUM_REGS; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    regs_q[i] <= wr_data;
                end
            end
        end
    end

    // Read ports with same-cycle write-through
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            if (rd_idx[p] == '0) begin
                rd_data[p] = '0;
            end else if (wr_en && (wr_idx == rd_idx[p])) begin
                rd_data[p] = wr_data;
            end else begin
                rd_data[p] = regs_q[rd_idx[p]];
            end
        end
    end

    // R7
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != '0)) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

    // R4
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == '0)) |=> (regs_q[0] == '0));

endmodule

// File: rtl/byp_match.sv
module byp_match
    import byp_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             xm_wen,
    input  logic [IDX_W-1:0] xm_dst,
    input  logic             mw_wen,
    input  logic [IDX_W-1:0] mw_dst,
    output opnd_src_e        sel
);

    logic xm_hit;
    logic mw_hit;

    always_comb begin
        xm_hit = xm_wen && (xm_dst != '0) && (xm_dst == src_idx);
        mw_hit = mw_wen && (mw_dst != '0) && (mw_dst == src_idx);
    end

    // Younger stage first
    always_comb begin
        if (xm_hit) begin
            sel = SRC_XM;
        end else if (mw_hit) begin
            sel = SRC_MW;
        end else begin
            sel = SRC_RF;
        end
    end

endmodule

// File: rtl/byp_opnd_mux.sv
module byp_opnd_mux
    import byp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opnd_src_e         sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] xm_val,
    input  logic [DATA_W-1:0] mw_val,
    output logic [DATA_W-1:0] opnd_val
);

    always_comb begin
        unique case (sel)
            SRC_XM:  opnd_val = xm_val;
            SRC_MW:  opnd_val = mw_val;
            default: opnd_val = rf_val;
        endcase
    end

endmodule

// File: rtl/exec_bypass_unit.sv
module exec_bypass_unit
    import byp_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int NUM_OPND = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  dec_rd_a_idx,
    input  logic [IDX_W-1:0]  dec_rd_b_idx,
    output logic [DATA_W-1:0] dec_rd_a_data,
    output logic [DATA_W-1:0] dec_rd_b_data,
    input  logic [IDX_W-1:0]  ex_src_a_idx,
    input  logic [IDX_W-1:0]  ex_src_b_idx,
    input  logic [DATA_W-1:0] ex_rf_a_val,
    input  logic [DATA_W-1:0] ex_rf_b_val,
    input  logic              xm_wr_en,
    input  logic [IDX_W-1:0]  xm_dst_idx,
    input  logic [DATA_W-1:0] xm_alu_val,
    input  logic              mw_wr_en,
    input  logic [IDX_W-1:0]  mw_dst_idx,
    input  logic [DATA_W-1:0] mw_alu_val,
    input  logic [DATA_W-1:0] mw_load_val,
    input  logic              mw_is_load,
    output logic [1:0]        opnd_a_sel,
    output logic [1:0]        opnd_b_sel,
    output logic [DATA_W-1:0] opnd_a_val,
    output logic [DATA_W-1:0] opnd_b_val
);

    logic [DATA_W-1:0] wb_final;
    logic [IDX_W-1:0]  rd_idx   [NUM_OPND];
    logic [DATA_W-1:0] rd_data  [NUM_OPND];
    logic [IDX_W-1:0]  src_idx  [NUM_OPND];
    logic [DATA_W-1:0] rf_carry [NUM_OPND];
    opnd_src_e         sel_w    [NUM_OPND];
    logic [DATA_W-1:0] val_w    [NUM_OPND];

    // Final writeback value: shared by bypass and register write
    always_comb begin
        wb_final = mw_is_load ? mw_load_val : mw_alu_val;
    end

    always_comb begin
        rd_idx[0]   = dec_rd_a_idx;
        rd_idx[1]   = dec_rd_b_idx;
        src_idx[0]  = ex_src_a_idx;
        src_idx[1]  = ex_src_b_idx;
        rf_carry[0] = ex_rf_a_val;
        rf_carry[1] = ex_rf_b_val;
    end

    byp_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .NUM_RD   (NUM_OPND)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mw_wr_en),
        .wr_idx  (mw_dst_idx),
        .wr_data (wb_final),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        byp_match #(
            .IDX_W (IDX_W)
        ) u_match (
            .src_idx (src_idx[g]),
            .xm_wen  (xm_wr_en),
            .xm_dst  (xm_dst_idx),
            .mw_wen  (mw_wr_en),
            .mw_dst  (mw_dst_idx),
            .sel     (sel_w[g])
        );

        byp_opnd_mux #(
            .DATA_W (DATA_W)
        ) u_mux (
            .sel      (sel_w[g]),
            .rf_val   (rf_carry[g]),
            .xm_val   (xm_alu_val),
            .mw_val   (wb_final),
            .opnd_val (val_w[g])
        );
    end

    always_comb begin
        dec_rd_a_data = rd_data[0];
        dec_rd_b_data = rd_data[1];
        opnd_a_sel    = sel_w[0];
        opnd_b_sel    = sel_w[1];
        opnd_a_val    = val_w[0];
        opnd_b_val    = val_w[1];
    end

    // R1
    xm_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_a_sel == 2'b01) |-> (opnd_a_val == xm_alu_val));

    // R6
    mw_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_b_sel == 2'b10) |-> (opnd_b_val == (mw_is_load ? mw_load_val : mw_alu_val)));

    // R3
    younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_wr_en && mw_wr_en && (xm_dst_idx != '0) && (xm_dst_idx == mw_dst_idx)
         && (ex_src_a_idx == xm_dst_idx)) |-> (opnd_a_sel == 2'b01));

    // R4
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_b_idx == '0) |-> ((opnd_b_sel == 2'b00) && (opnd_b_val == ex_rf_b_val)));

    // R5
    no_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xm_wr_en && !mw_wr_en) |-> ((opnd_a_sel == 2'b00) && (opnd_b_sel == 2'b00)));

endmodule

// File: tb/test_exec_bypass_unit.sv
module test_exec_bypass_unit;

    localparam int NP = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  dec_rd_a_idx, dec_rd_b_idx, ex_src_a_idx, ex_src_b_idx;
    logic [2:0]  xm_dst_idx, mw_dst_idx;
    logic [31:0] dec_rd_a_data, dec_rd_b_data, ex_rf_a_val, ex_rf_b_val;
    logic [31:0] xm_alu_val, mw_alu_val, mw_load_val, opnd_a_val, opnd_b_val;
    logic        xm_wr_en, mw_wr_en, mw_is_load;
    logic [1:0]  opnd_a_sel, opnd_b_sel;

    always #5 clk = ~clk;

    exec_bypass_unit i_exec_bypass_unit (
        .clk(clk), .rst_n(rst_n),
        .dec_rd_a_idx(dec_rd_a_idx), .dec_rd_b_idx(dec_rd_b_idx),
        .dec_rd_a_data(dec_rd_a_data), .dec_rd_b_data(dec_rd_b_data),
        .ex_src_a_idx(ex_src_a_idx), .ex_src_b_idx(ex_src_b_idx),
        .ex_rf_a_val(ex_rf_a_val), .ex_rf_b_val(ex_rf_b_val),
        .xm_wr_en(xm_wr_en), .xm_dst_idx(xm_dst_idx), .xm_alu_val(xm_alu_val),
        .mw_wr_en(mw_wr_en), .mw_dst_idx(mw_dst_idx), .mw_alu_val(mw_alu_val),
        .mw_load_val(mw_load_val), .mw_is_load(mw_is_load),
        .opnd_a_sel(opnd_a_sel), .opnd_b_sel(opnd_b_sel),
        .opnd_a_val(opnd_a_val), .opnd_b_val(opnd_b_val)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    event chk_ev;

    // Scoreboard queues: field 0 a_sel, 1 b_sel, 2 a_val, 3 b_val, 4 dec_a, 5 dec_b
    string       tag_q[$];
    int          fld_q[$];
    logic [31:0] exp_q[$];

    task automatic push(input string tag, input int fld, input logic [31:0] e);
        tag_q.push_back(tag);
        fld_q.push_back(fld);
        exp_q.push_back(e);
    endtask

    function automatic logic [31:0] actual(input int fld);
        case (fld)
            0: return {30'd0, opnd_a_sel};
            1: return {30'd0, opnd_b_sel};
            2: return opnd_a_val;
            3: return opnd_b_val;
            4: return dec_rd_a_data;
            default: return dec_rd_b_data;
        endcase
    endfunction

    // Monitor: compares queued expectations when the driver signals
    initial begin
        forever begin
            @(chk_ev);
            while (fld_q.size() > 0) begin
                string       t;
                int          f;
                logic [31:0] e;
                logic [31:0] a;
                t = tag_q.pop_front();
                f = fld_q.pop_front();
                e = exp_q.pop_front();
                a = actual(f);
                n_checks++;
                if (a !== e) begin
                    n_errors++;
                    $display("FAIL %s field %0d: actual %h expected %h", t, f, a, e);
                end
            end
        end
    end

    task automatic fire();
        #4;
        -> chk_ev;
        #0;
    endtask

    task automatic clr_inputs();
        dec_rd_a_idx = '0; dec_rd_b_idx = '0;
        ex_src_a_idx = '0; ex_src_b_idx = '0;
        ex_rf_a_val = '0;  ex_rf_b_val = '0;
        xm_wr_en = 1'b0;   xm_dst_idx = '0; xm_alu_val = '0;
        mw_wr_en = 1'b0;   mw_dst_idx = '0; mw_alu_val = '0;
        mw_load_val = '0;  mw_is_load = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clr_inputs();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Program for the dependence replay
    int          p_dst[NP], p_sa[NP], p_sb[NP];
    bit          p_wen[NP], p_ld[NP];
    logic [31:0] p_val[NP];
    logic [31:0] exp_a[NP], exp_b[NP];
    logic [31:0] rfm[8];

    task automatic put(input int i, input bit w, input int d, input int a,
                       input int b, input bit ld, input logic [31:0] v);
        p_wen[i] = w; p_dst[i] = d; p_sa[i] = a; p_sb[i] = b;
        p_ld[i] = ld; p_val[i] = v;
    endtask

    function automatic bit ok(input int i);
        return (i >= 0) && (i < NP);
    endfunction

    function automatic bit writes(input int i, input int r);
        return ok(i) && p_wen[i] && (p_dst[i] != 0) && (p_dst[i] == r);
    endfunction

    function automatic logic [31:0] rd_model(input int idx, input int w);
        if (idx == 0) return '0;
        if (writes(w, idx)) return p_val[w];
        return rfm[idx];
    endfunction

    function automatic logic [31:0] sel_model(input int e, input int src);
        if (writes(e - 1, src)) return 32'd1;
        if (writes(e - 2, src)) return 32'd2;
        return 32'd0;
    endfunction

    initial begin
        logic [31:0] arch[8];
        logic [31:0] carry_a, carry_b;
        rst_n = 1'b0;
        clr_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R7: every register reads zero after reset
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            dec_rd_a_idx = 3'(r);
            dec_rd_b_idx = 3'(7 - r);
            push("R7 reset a", 4, 32'd0);
            push("R7 reset b", 5, 32'd0);
            fire();
        end

        // R5: matching destination with write enable low
        @(negedge clk);
        clr_inputs();
        ex_src_a_idx = 3'd3; ex_rf_a_val = 32'h0000_1234;
        xm_dst_idx = 3'd3; xm_alu_val = 32'hFFFF_0001;
        mw_dst_idx = 3'd3; mw_alu_val = 32'hFFFF_0002;
        push("R5 sel", 0, 32'd0);
        push("R5 val", 2, 32'h0000_1234);
        fire();

        // R4: register zero source with enabled zero destination
        @(negedge clk);
        clr_inputs();
        ex_src_b_idx = 3'd0; ex_rf_b_val = 32'h0000_0077;
        xm_wr_en = 1'b1; xm_dst_idx = 3'd0; xm_alu_val = 32'hFFFF_FFFF;
        push("R4 sel", 1, 32'd0);
        push("R4 val", 3, 32'h0000_0077);
        fire();

        // R6 and R9: A from execute/memory, B from memory/writeback ALU result
        @(negedge clk);
        clr_inputs();
        ex_src_a_idx = 3'd2; ex_src_b_idx = 3'd4;
        xm_wr_en = 1'b1; xm_dst_idx = 3'd2; xm_alu_val = 32'h0000_AAAA;
        mw_wr_en = 1'b1; mw_dst_idx = 3'd4; mw_alu_val = 32'h0000_CAFE;
        mw_load_val = 32'h0000_BEEF; mw_is_load = 1'b0;
        push("R9 a sel", 0, 32'd1);
        push("R9 a val", 2, 32'h0000_AAAA);
        push("R9 b sel", 1, 32'd2);
        push("R6 alu val", 3, 32'h0000_CAFE);
        fire();

        // R6: same, load flag set
        @(negedge clk);
        mw_is_load = 1'b1;
        push("R6 load sel", 1, 32'd2);
        push("R6 load val", 3, 32'h0000_BEEF);
        fire();

        // Dependence replay (distances 1, 2, 3)
        put(0,  1, 1, 0, 0, 0, 32'd11);
        put(1,  1, 2, 1, 0, 0, 32'd22);
        put(2,  1, 3, 1, 2, 0, 32'd33);
        put(3,  1, 4, 1, 3, 0, 32'd44);
        put(4,  0, 0, 4, 2, 0, 32'd0);
        put(5,  1, 5, 3, 4, 1, 32'd55);
        put(6,  0, 0, 0, 0, 0, 32'd0);
        put(7,  1, 6, 5, 5, 0, 32'd66);
        put(8,  1, 5, 6, 1, 0, 32'd88);
        put(9,  1, 5, 2, 6, 0, 32'd99);
        put(10, 1, 7, 5, 5, 0, 32'd70);
        put(11, 1, 0, 7, 1, 0, 32'd77);
        put(12, 1, 2, 0, 0, 0, 32'd12);
        put(13, 1, 1, 7, 6, 0, 32'd123);

        for (int r = 0; r < 8; r++) begin
            arch[r] = '0;
            rfm[r] = '0;
        end
        for (int i = 0; i < NP; i++) begin
            exp_a[i] = arch[p_sa[i]];
            exp_b[i] = arch[p_sb[i]];
            if (p_wen[i] && (p_dst[i] != 0)) arch[p_dst[i]] = p_val[i];
        end

        do_reset();
        carry_a = '0;
        carry_b = '0;
        for (int t = 0; t < NP + 4; t++) begin
            int d, e, m, w;
            logic [31:0] nxt_a, nxt_b;
            d = t; e = t - 1; m = t - 2; w = t - 3;
            @(negedge clk);
            dec_rd_a_idx = ok(d) ? 3'(p_sa[d]) : 3'd0;
            dec_rd_b_idx = ok(d) ? 3'(p_sb[d]) : 3'd0;
            ex_src_a_idx = ok(e) ? 3'(p_sa[e]) : 3'd0;
            ex_src_b_idx = ok(e) ? 3'(p_sb[e]) : 3'd0;
            ex_rf_a_val = carry_a;
            ex_rf_b_val = carry_b;
            xm_wr_en   = ok(m) && p_wen[m];
            xm_dst_idx = ok(m) ? 3'(p_dst[m]) : 3'd0;
            xm_alu_val = ok(m) ? p_val[m] : 32'd0;
            mw_wr_en   = ok(w) && p_wen[w];
            mw_dst_idx = ok(w) ? 3'(p_dst[w]) : 3'd0;
            mw_is_load = ok(w) && p_ld[w];
            mw_alu_val  = (ok(w) && p_ld[w]) ? (32'hA5A5_0000 | 32'(w)) : (ok(w) ? p_val[w] : 32'd0);
            mw_load_val = (ok(w) && p_ld[w]) ? p_val[w] : (32'h5A5A_0000 | 32'(t));

            nxt_a = rd_model(ok(d) ? p_sa[d] : 0, w);
            nxt_b = rd_model(ok(d) ? p_sb[d] : 0, w);
            // R8: decode reads include the same-cycle writeback
            push("R8 dec a", 4, nxt_a);
            push("R8 dec b", 5, nxt_b);
            if (ok(e)) begin
                // R1 R2 R3 R10: select and in-order operand value
                push("R1/R2 replay a sel", 0, sel_model(e, p_sa[e]));
                push("R1/R2 replay b sel", 1, sel_model(e, p_sb[e]));
                push("R3 replay a val", 2, exp_a[e]);
                push("R3 replay b val", 3, exp_b[e]);
            end else begin
                push("R10 idle a sel", 0, 32'd0);
                push("R10 idle b val", 3, carry_b);
            end
            fire();
            if (writes(w, ok(w) ? p_dst[w] : 0)) rfm[p_dst[w]] = p_val[w];
            carry_a = nxt_a;
            carry_b = nxt_b;
        end

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule